// File: doc/BRIEF.md
# LUT Ramp Pattern Sequencer

This block drives the duty value of one or more PWM generators from a shared table of 9-bit brightness levels. Each channel walks a window of the table, bounded by a low and a high index, and holds every entry for a programmable number of timebase ticks. The current entry's table value is presented as the duty value. At either end of the window a channel can dwell for a longer pause, reverse direction (ping-pong), jump back to its starting entry, or stop and raise a done flag.

The table is a 47-entry memory that is written and read back through a simple address/data port. A single start strobe restarts every enabled channel on the same clock edge. Channels that are given the same settings therefore stay in phase. Each channel captures its settings when it starts, so software can prepare the next pattern while the current one plays. The millisecond timebase is supplied from outside as a one-cycle tick.

Top module: `lut_ramp_seq`

## Requirements
- R1: After reset every channel reports index 0, done low and duty 0, and every table entry reads back as 0.
- R2: A write with `tbl_addr` below 47 stores `tbl_wdata` in that entry. `tbl_rdata` returns the entry at `tbl_addr` one clock later. Writes with an address of 47 or more change no entry.
- R3: Mode field bits: bit 0 enables the low-end pause, bit 1 enables the high-end pause, bit 2 enables ping-pong, bit 3 enables repeat, and bit 4 selects upward travel. A start with `run_en` high and a valid window sets the index, on the next cycle, to the low index (bit 4 set) or the high index (bit 4 clear), clears done and restarts the hold count.
- R4: While running, each entry is held for `step` ticks, with a step of 0 treated as 1. The index then moves by one toward the end of the current direction. Cycles without `tick` never move the index.
- R5: At the high index, with bit 1 set and a nonzero high multiplier, the entry is held for multiplier × step ticks. The low end works the same way with bit 0 and the low multiplier. A zero multiplier leaves the hold at one step.
- R6: With bits 2 and 3 clear, after the far end's hold the channel raises done and keeps its index until the next start or until `run_en` falls.
- R7: With bit 3 set and bit 2 clear, the entry after the far end is the starting index.
- R8: With bit 2 set, the channel reverses at an end and moves one entry in the new direction. With bit 3 also set it reverses forever. Without bit 3 it raises done after the hold at the starting end, once it has returned there.
- R9: Each channel's duty equals the table entry at its index. An index of 47 yields duty 0.
- R10: A start is ignored by a channel whose window is invalid (low ≥ 47, high > 47, or high ≤ low). Its index and done keep their values.
- R11: A start affects only channels with `run_en` high. Channels with identical settings produce identical index, duty and done on every cycle after a common start.
- R12: With `run_en` low, a channel stops on the next cycle: done is cleared, and the index holds even while ticks arrive.
- R13: Settings are captured at start. Changing the configuration inputs while a channel runs has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse, one step-count unit |
| start | input | 1 | Common restart strobe |
| run_en | input | NUM_CH | Per-channel ramp enable |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IW | Table write/read address |
| tbl_wdata | input | VW | Table write data |
| tbl_rdata | output | VW | Registered table read data |
| cfg_lo | input | NUM_CH*IW | Low window index per channel |
| cfg_hi | input | NUM_CH*IW | High window index per channel |
| cfg_step | input | NUM_CH*SW | Ticks per entry per channel |
| cfg_pause_hi | input | NUM_CH*PW | High-end pause multiplier per channel |
| cfg_pause_lo | input | NUM_CH*PW | Low-end pause multiplier per channel |
| cfg_mode | input | NUM_CH*5 | Mode field per channel (bits per R3) |
| duty | output | NUM_CH*VW | Current duty value per channel |
| index | output | NUM_CH*IW | Current table index per channel |
| done | output | NUM_CH | Pattern finished per channel |

## Verification
The bench loads a known table and then sweeps every combination of direction, ping-pong and repeat, plus pauses, zero multipliers, zero step and a window that ends at index 47. On every cycle it compares each channel's index, duty and done with an arithmetic walk of the pattern. Some faults are aimed at directly. If an end were held twice on reversal, or a wrap went to the far end instead of the start, the index trace would shift by one step. If the pause multiplier were applied at the wrong end, or with a zero value, the hold counts would come out wrong. If the settings were read live rather than captured, the trace would change when the inputs are altered mid-run. Further cases cover invalid windows, disabled channels at a start, and out-of-range table writes; a design that let any of these through would show a moved index or a corrupted readback.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef struct packed {
    logic up;        // bit 4: travel low to high
    logic rpt;       // bit 3: repeat
    logic toggle;    // bit 2: ping-pong
    logic pause_hi;  // bit 1: dwell at high end
    logic pause_lo;  // bit 0: dwell at low end
  } lrs_mode_t;

  localparam int LRS_MODE_W = 5;

  // Ticks an entry is held: a zero step counts as one, a nonzero multiplier scales it.
  function automatic int lrs_dwell(input int step, input int mult);
    int s;
    s = (step == 0) ? 1 : step;
    return (mult == 0) ? s : s * mult;
  endfunction

  function automatic logic lrs_window_ok(input int lo, input int hi, input int depth);
    return (lo < depth) && (hi <= depth) && (hi > lo);
  endfunction

endpackage

// File: rtl/lrs_table.sv
module lrs_table #(
  parameter int DEPTH = 47,
  parameter int VW    = 9,
  parameter int IW    = 6,
  parameter int NRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     addr,
  input  logic [VW-1:0]     wdata,
  output logic [VW-1:0]     rdata,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*VW-1:0] rd_val
);

  logic [VW-1:0] mem [DEPTH];
  logic          addr_ok;

  assign addr_ok = 32'(addr) < DEPTH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && addr_ok) mem[addr] <= wdata;
      rdata <= addr_ok ? mem[addr] : '0;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [IW-1:0] ri;
    assign ri = rd_idx[g*IW +: IW];
    assign rd_val[g*VW +: VW] = (32'(ri) < DEPTH) ? mem[ri] : '0;
  end

  // R2: out-of-range addresses always read back as zero
  assert_oob_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(addr) >= DEPTH) |=> (rdata == '0));

endmodule

// File: rtl/lrs_channel.sv
module lrs_channel
  import lrs_pkg::*;
#(
  parameter int DEPTH = 47,
  parameter int IW    = 6,
  parameter int SW    = 16,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          run_en,
  input  logic [IW-1:0] cfg_lo,
  input  logic [IW-1:0] cfg_hi,
  input  logic [SW-1:0] cfg_step,
  input  logic [PW-1:0] cfg_phi,
  input  logic [PW-1:0] cfg_plo,
  input  lrs_mode_t     cfg_mode,
  output logic [IW-1:0] idx,
  output logic          done
);

  localparam int TW = SW + PW;

  logic [IW-1:0] idx_q, lo_q, hi_q;
  logic [SW-1:0] step_q;
  logic [PW-1:0] phi_q, plo_q;
  lrs_mode_t     mode_q;
  logic          up_q, active_q, done_q;
  logic [TW-1:0] timer_q, dwell;
  logic [PW-1:0] mult_sel;

  // named events
  logic start_ok, at_hi, at_lo, at_target, turned;
  logic step_done, evt_reverse, evt_wrap, evt_finish;

  assign start_ok  = start && run_en && lrs_window_ok(int'(cfg_lo), int'(cfg_hi), DEPTH);
  assign at_hi     = idx_q == hi_q;
  assign at_lo     = idx_q == lo_q;
  assign at_target = up_q ? at_hi : at_lo;
  assign turned    = up_q != mode_q.up;

  always_comb begin
    mult_sel = '0;
    if (at_hi && mode_q.pause_hi)      mult_sel = phi_q;
    else if (at_lo && mode_q.pause_lo) mult_sel = plo_q;
  end

  assign dwell       = TW'(lrs_dwell(int'(step_q), int'(mult_sel)));
  assign step_done   = active_q && tick && (timer_q >= dwell - TW'(1));
  assign evt_reverse = at_target && mode_q.toggle && (mode_q.rpt || !turned);
  assign evt_wrap    = at_target && !evt_reverse && mode_q.rpt;
  assign evt_finish  = at_target && !evt_reverse && !mode_q.rpt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; lo_q <= '0; hi_q <= '0; step_q <= '0;
      phi_q <= '0; plo_q <= '0; mode_q <= '0;
      up_q <= 1'b0; active_q <= 1'b0; done_q <= 1'b0; timer_q <= '0;
    end else if (start_ok) begin
      lo_q <= cfg_lo; hi_q <= cfg_hi; step_q <= cfg_step;
      phi_q <= cfg_phi; plo_q <= cfg_plo; mode_q <= cfg_mode;
      idx_q <= cfg_mode.up ? cfg_lo : cfg_hi;
      up_q <= cfg_mode.up; active_q <= 1'b1; done_q <= 1'b0; timer_q <= '0;
    end else if (!run_en) begin
      active_q <= 1'b0; done_q <= 1'b0;
    end else if (active_q && tick) begin
      if (step_done) begin
        timer_q <= '0;
        if (!at_target) begin
          idx_q <= up_q ? idx_q + 1'b1 : idx_q - 1'b1;
        end else if (evt_reverse) begin
          up_q  <= !up_q;
          idx_q <= up_q ? idx_q - 1'b1 : idx_q + 1'b1;
        end else if (evt_wrap) begin
          idx_q <= mode_q.up ? lo_q : hi_q;
        end else begin
          active_q <= 1'b0; done_q <= 1'b1;
        end
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign idx  = idx_q;
  assign done = done_q;

  // R3: an accepted start loads the starting index and clears done
  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (idx_q == $past(cfg_mode.up ? cfg_lo : cfg_hi)) && !done_q && active_q);

  // R4: a running channel stays inside its captured window
  assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q >= lo_q) && (idx_q <= hi_q));

  // R4: the index moves only when a hold completes
  assert_hold_until_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !start_ok && !step_done) |=> $stable(idx_q));

  // R5: hold counter never passes the current dwell
  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (timer_q < dwell));

  // R6: a finished channel holds still
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && run_en && !start_ok) |=> done_q && $stable(idx_q));

  // R7: wrap lands on the starting index
  assert_wrap_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && evt_wrap && run_en && !start_ok) |=> (idx_q == (mode_q.up ? lo_q : hi_q)));

  // R6/R8: finishing raises done
  assert_finish_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && evt_finish && run_en && !start_ok) |=> done_q);

  // R12: disable stops the channel
  assert_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !done_q && $stable(idx_q));

endmodule

// File: rtl/lut_ramp_seq.sv
module lut_ramp_seq
  import lrs_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 47,
  parameter int VW     = 9,
  parameter int IW     = 6,
  parameter int SW     = 16,
  parameter int PW     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       start,
  input  logic [NUM_CH-1:0]          run_en,
  input  logic                       tbl_we,
  input  logic [IW-1:0]              tbl_addr,
  input  logic [VW-1:0]              tbl_wdata,
  output logic [VW-1:0]              tbl_rdata,
  input  logic [NUM_CH*IW-1:0]       cfg_lo,
  input  logic [NUM_CH*IW-1:0]       cfg_hi,
  input  logic [NUM_CH*SW-1:0]       cfg_step,
  input  logic [NUM_CH*PW-1:0]       cfg_pause_hi,
  input  logic [NUM_CH*PW-1:0]       cfg_pause_lo,
  input  logic [NUM_CH*LRS_MODE_W-1:0] cfg_mode,
  output logic [NUM_CH*VW-1:0]       duty,
  output logic [NUM_CH*IW-1:0]       index,
  output logic [NUM_CH-1:0]          done
);

  logic [NUM_CH*IW-1:0] ch_idx;

  lrs_table #(.DEPTH(DEPTH), .VW(VW), .IW(IW), .NRD(NUM_CH)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .addr(tbl_addr), .wdata(tbl_wdata),
    .rdata(tbl_rdata), .rd_idx(ch_idx), .rd_val(duty)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lrs_mode_t mode_c;
    assign mode_c = lrs_mode_t'(cfg_mode[c*LRS_MODE_W +: LRS_MODE_W]);

    lrs_channel #(.DEPTH(DEPTH), .IW(IW), .SW(SW), .PW(PW)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .run_en(run_en[c]),
      .cfg_lo(cfg_lo[c*IW +: IW]), .cfg_hi(cfg_hi[c*IW +: IW]),
      .cfg_step(cfg_step[c*SW +: SW]),
      .cfg_phi(cfg_pause_hi[c*PW +: PW]), .cfg_plo(cfg_pause_lo[c*PW +: PW]),
      .cfg_mode(mode_c), .idx(ch_idx[c*IW +: IW]), .done(done[c])
    );
  end

  assign index = ch_idx;

endmodule

// File: tb/test_lut_ramp_seq.sv
`timescale 1ns/1ps
module test_lut_ramp_seq;

  localparam int NC = 2, IW = 6, VW = 9, SW = 16, PW = 8, MW = 5, DEPTH = 47;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [NC-1:0] run_en = '0;
  logic tbl_we = 1'b0;
  logic [IW-1:0] tbl_addr = '0;
  logic [VW-1:0] tbl_wdata = '0, tbl_rdata;
  logic [NC*IW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [NC*SW-1:0] cfg_step = '0;
  logic [NC*PW-1:0] cfg_pause_hi = '0, cfg_pause_lo = '0;
  logic [NC*MW-1:0] cfg_mode = '0;
  logic [NC*VW-1:0] duty;
  logic [NC*IW-1:0] index;
  logic [NC-1:0] done;

  always #2.5 clk = ~clk;

  lut_ramp_seq i_lut_ramp_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .run_en(run_en),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_step(cfg_step),
    .cfg_pause_hi(cfg_pause_hi), .cfg_pause_lo(cfg_pause_lo), .cfg_mode(cfg_mode),
    .duty(duty), .index(index), .done(done)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tv(input int i);
    return (i < DEPTH) ? ((i * 37 + 5) % 512) : 0;
  endfunction

  // reference model of channel 0
  int m_idx = 0, m_cnt = 0, c_lo = 0, c_hi = 0, c_step = 0, c_phi = 0, c_plo = 0;
  bit m_up = 0, m_act = 0, m_done = 0;
  bit [4:0] c_mode = '0;

  task automatic set_cfg(input int lo, input int hi, input int st, input int phi,
                         input int plo, input bit [4:0] md);
    for (int c = 0; c < NC; c++) begin
      cfg_lo[c*IW +: IW] = IW'(lo);  cfg_hi[c*IW +: IW] = IW'(hi);
      cfg_step[c*SW +: SW] = SW'(st);
      cfg_pause_hi[c*PW +: PW] = PW'(phi); cfg_pause_lo[c*PW +: PW] = PW'(plo);
      cfg_mode[c*MW +: MW] = md;
    end
  endtask

  task automatic model_tick();
    int hold, tgt;
    hold = (c_step == 0) ? 1 : c_step;
    if (m_idx == c_hi && c_mode[1] && c_phi != 0) hold = hold * c_phi;
    else if (m_idx == c_lo && c_mode[0] && c_plo != 0) hold = hold * c_plo;
    if (!m_act) return;
    if (m_cnt + 1 < hold) begin m_cnt++; return; end
    m_cnt = 0;
    tgt = m_up ? c_hi : c_lo;
    if (m_idx != tgt) m_idx = m_up ? m_idx + 1 : m_idx - 1;
    else if (c_mode[2] && (c_mode[3] || m_up == c_mode[4])) begin
      m_up = !m_up; m_idx = m_up ? m_idx + 1 : m_idx - 1;
    end else if (c_mode[3]) m_idx = c_mode[4] ? c_lo : c_hi;
    else begin m_act = 0; m_done = 1; end
  endtask

  task automatic do_start();
    int lo, hi;
    lo = int'(cfg_lo[IW-1:0]); hi = int'(cfg_hi[IW-1:0]);
    tick = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!run_en[0]) begin m_act = 0; m_done = 0; end
    else if (lo < DEPTH && hi <= DEPTH && hi > lo) begin
      c_lo = lo; c_hi = hi; c_step = int'(cfg_step[SW-1:0]);
      c_phi = int'(cfg_pause_hi[PW-1:0]); c_plo = int'(cfg_pause_lo[PW-1:0]);
      c_mode = cfg_mode[MW-1:0];
      m_up = c_mode[4]; m_idx = m_up ? lo : hi; m_cnt = 0; m_act = 1; m_done = 0;
    end
  endtask

  task automatic run(input string req, input int n, input bit tk, input bit sync);
    for (int k = 0; k < n; k++) begin
      chk(req, int'(index[IW-1:0]), m_idx);
      chk({req, " R9"}, int'(duty[VW-1:0]), tv(m_idx));
      chk(req, int'(done[0]), int'(m_done));
      if (sync) begin
        chk("R11 idx", int'(index[2*IW-1:IW]), int'(index[IW-1:0]));
        chk("R11 done", int'(done[1]), int'(done[0]));
      end
      tick = tk;
      @(negedge clk);
      if (!run_en[0]) begin m_act = 0; m_done = 0; end
      else if (tk) model_tick();
    end
    tick = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idx", int'(index), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 duty", int'(duty), 0);
    rst_n = 1'b1;
    @(negedge clk);
    tbl_addr = 6'd5; @(negedge clk);
    chk("R1 table", int'(tbl_rdata), 0);

    // R2 table load and readback, plus ignored out-of-range write
    for (int i = 0; i < DEPTH; i++) begin
      tbl_we = 1'b1; tbl_addr = IW'(i); tbl_wdata = VW'(tv(i)); @(negedge clk);
    end
    tbl_addr = 6'd50; tbl_wdata = 9'h1ff; @(negedge clk);
    tbl_addr = 6'd47; @(negedge clk);
    tbl_we = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      tbl_addr = IW'(i); @(negedge clk);
      chk("R2 readback", int'(tbl_rdata), tv(i));
    end
    tbl_addr = 6'd47; @(negedge clk);
    chk("R2 oob read", int'(tbl_rdata), 0);

    run_en = 2'b11;
    // R3 R4 R6: upward once
    set_cfg(3, 7, 2, 0, 0, 5'b10000);
    do_start();
    chk("R3 start idx", int'(index[IW-1:0]), 3);
    run("R4 R6 up-once", 16, 1'b1, 1'b1);
    chk("R6 done", int'(done[0]), 1);
    run("R6 hold", 4, 1'b1, 1'b1);

    // R7 downward repeat, step 0; R4 no-tick stall
    set_cfg(10, 13, 0, 0, 0, 5'b01000);
    do_start();
    chk("R3 start down", int'(index[IW-1:0]), 13);
    run("R7 wrap", 6, 1'b1, 1'b1);
    run("R4 no tick", 5, 1'b0, 1'b1);
    run("R7 wrap", 8, 1'b1, 1'b1);

    // R5 R8 ping-pong repeat with pauses
    set_cfg(0, 4, 3, 2, 3, 5'b11111);
    do_start();
    run("R5 R8 pingpong", 90, 1'b1, 1'b1);

    // R8 R9 ping-pong once, downward, window touching 47
    set_cfg(44, 47, 1, 0, 0, 5'b00100);
    do_start();
    chk("R9 idx47 duty", int'(duty[VW-1:0]), 0);
    run("R8 pingpong-once", 10, 1'b1, 1'b1);
    chk("R8 done", int'(done[0]), 1);

    // R5 pause enabled with zero multipliers
    set_cfg(20, 22, 2, 0, 0, 5'b10011);
    do_start();
    run("R5 zero mult", 10, 1'b1, 1'b1);

    // R13 config change mid-run
    set_cfg(30, 33, 2, 0, 0, 5'b11000);
    do_start();
    run("R13 before", 3, 1'b1, 1'b1);
    set_cfg(1, 2, 5, 4, 4, 5'b00111);
    run("R13 after change", 12, 1'b1, 1'b1);

    // R10 invalid windows ignored
    keep = m_idx;
    set_cfg(9, 9, 1, 0, 0, 5'b10000);
    do_start();
    chk("R10 equal idx", int'(index[IW-1:0]), keep);
    set_cfg(40, 48, 1, 0, 0, 5'b10000);
    do_start();
    chk("R10 hi48", int'(index[IW-1:0]), keep);
    set_cfg(47, 47, 1, 0, 0, 5'b10000);
    do_start();
    run("R10 after bad", 3, 1'b1, 1'b1);

    // R12 disable mid-run (channel 0 only)
    set_cfg(5, 9, 1, 0, 0, 5'b10000);
    do_start();
    run("R12 pre", 2, 1'b1, 1'b1);
    run_en = 2'b10;
    run("R12 halted", 6, 1'b1, 1'b0);
    chk("R12 done low", int'(done[0]), 0);

    // R11 start ignored by disabled channel, then common realign
    set_cfg(12, 16, 2, 0, 0, 5'b11100);
    keep = m_idx;
    do_start();
    chk("R11 disabled ignores start", int'(index[IW-1:0]), keep);
    chk("R11 enabled starts", int'(index[2*IW-1:IW]), 12);
    run("R11 ch1 alone", 5, 1'b1, 1'b0);
    run_en = 2'b11;
    do_start();
    run("R11 aligned", 30, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule